// File: doc/BRIEF.md
# Ramp Timebase with Blanking and Clock Sync

This block is the timing source of a fixed-frequency, two-output PWM controller, built as a digital counter in place of a charged timing capacitor. A ramp code rises from a lower threshold toward an upper threshold by a programmable step each clock. When it reaches the upper threshold it falls back to the lower threshold at ten times the base step. The present ramp code is exported so that a voltage-mode comparator can use it directly.

The falling phase is the blanking window. Blanking resets the PWM latch, holds the outputs off and advances the output steering state, which the block also provides. In master mode the clock pin is driven high for the whole falling phase. In slave mode the pin is an input: an external pulse produces blanking but leaves the ramp alone, so driving the pin does not resynchronise the timebase. An extra step added to the rising slope shortens the rise but not the fall. This lengthens the blanking share of each period and so adds dead time.

Top module: `ramp_timebase`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `ramp_level` equals `LO_CODE`, `fall_phase` is 0, `blank` is 0, `sync_out` is 0 and `steer` is 0.
- R2: In the rising phase, each clock adds `rise_step + extra_step` to `ramp_level`. If the sum would reach or pass `HI_CODE`, the level is set to `HI_CODE` and `fall_phase` becomes 1 in the same cycle.
- R3: In the falling phase, each clock subtracts `FALL_RATIO * rise_step` (default ratio 10) from `ramp_level`. If the result would reach or go below `LO_CODE`, the level is set to `LO_CODE` and `fall_phase` returns to 0.
- R4: `blank` is 1 in every cycle where `fall_phase` is 1, in both modes.
- R5: With `master_sel` = 1, `sync_oe` is 1 and `sync_out` equals `fall_phase` every cycle.
- R6: With `master_sel` = 0, `sync_oe` and `sync_out` are 0. A high on `sync_in` makes `blank` high one cycle later. The ramp level and phase follow the same path they would follow with `sync_in` held low.
- R7: `steer` inverts on the clock edge that follows each cycle in which `blank` goes from 0 to 1, and holds otherwise.
- R8: A nonzero `extra_step` speeds up the rise only. The fall decrement stays `FALL_RATIO * rise_step`, so the falling share of the period grows.
- R9: When the step that applies to the current phase is zero, `ramp_level` and `fall_phase` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rise_step | input | STEP_W | Base rising increment; the fall decrement is FALL_RATIO times this |
| extra_step | input | STEP_W | Additional rising increment for dead-time control |
| master_sel | input | 1 | 1 = drive the clock pin, 0 = sample it |
| sync_in | input | 1 | Clock pin input path, used in slave mode |
| ramp_level | output | RAMP_W | Current ramp code |
| fall_phase | output | 1 | 1 while the ramp falls |
| blank | output | 1 | Blanking pulse to the PWM latch and output gating |
| sync_out | output | 1 | Clock pin output value |
| sync_oe | output | 1 | Clock pin output enable |
| steer | output | 1 | Steering state selecting the active output |

## Verification
The bench drives large steps so the ramp overshoots both thresholds. A design that did not clamp would leave the window or stretch the fall by one cycle. It also runs cases with a nonzero extra step, where a design that scaled the fall by the total step would shrink the dead time instead of growing it. Slave-mode runs pulse the clock pin in the middle of rising phases and inside falling phases. A design that restarted the ramp, missed the one-cycle sampling delay or toggled steering on every blank cycle would diverge from the model. Zero-step stretches in both phases catch a ramp that drifts or flips phase when it should hold.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } phase_e;

    localparam int unsigned DEF_FALL_RATIO = 10;

    typedef struct packed {
        logic blank;
        logic clk_drv;
        logic clk_oe;
        logic steer;
    } edge_out_t;

    function automatic logic phase_is_fall(input phase_e ph);
        return ph == PH_FALL;
    endfunction

endpackage

// File: rtl/ramp_core.sv
module ramp_core
    import ramp_pkg::*;
#(
    parameter int unsigned RAMP_W     = 12,
    parameter int unsigned STEP_W     = 6,
    parameter int unsigned LO_CODE    = 100,
    parameter int unsigned HI_CODE    = 280,
    parameter int unsigned FALL_RATIO = DEF_FALL_RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] rise_step,
    input  logic [STEP_W-1:0] extra_step,
    output logic [RAMP_W-1:0] level,
    output phase_e            phase
);
    localparam int unsigned SUM_W  = STEP_W + 1;
    localparam int unsigned FALL_W = STEP_W + $clog2(FALL_RATIO + 1);
    localparam int unsigned EXT_W  = RAMP_W + 2;
    localparam logic [EXT_W-1:0] LO_EXT = EXT_W'(LO_CODE);
    localparam logic [EXT_W-1:0] HI_EXT = EXT_W'(HI_CODE);

    logic [SUM_W-1:0]  up_step;
    logic [FALL_W-1:0] down_step;
    logic [EXT_W-1:0]  up_sum;
    logic [EXT_W-1:0]  lo_guard;
    logic [EXT_W-1:0]  level_ext;
    logic [RAMP_W-1:0] level_nxt;
    phase_e            phase_nxt;

    assign up_step   = SUM_W'(rise_step) + SUM_W'(extra_step);
    assign down_step = FALL_W'(rise_step) * FALL_W'(FALL_RATIO);
    assign level_ext = EXT_W'(level);
    assign up_sum    = level_ext + EXT_W'(up_step);
    assign lo_guard  = LO_EXT + EXT_W'(down_step);

    always_comb begin
        level_nxt = level;
        phase_nxt = phase;
        unique case (phase)
            PH_RISE: begin
                if (up_step != '0) begin
                    if (up_sum >= HI_EXT) begin
                        level_nxt = RAMP_W'(HI_CODE);
                        phase_nxt = PH_FALL;
                    end else begin
                        level_nxt = up_sum[RAMP_W-1:0];
                    end
                end
            end
            PH_FALL: begin
                if (down_step != '0) begin
                    if (level_ext <= lo_guard) begin
                        level_nxt = RAMP_W'(LO_CODE);
                        phase_nxt = PH_RISE;
                    end else begin
                        level_nxt = level - RAMP_W'(down_step);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= RAMP_W'(LO_CODE);
            phase <= PH_RISE;
        end else begin
            level <= level_nxt;
            phase <= phase_nxt;
        end
    end

    assert_level_window_R2: assert property (@(posedge clk) disable iff (rst)
        (level >= RAMP_W'(LO_CODE)) && (level <= RAMP_W'(HI_CODE)));

    assert_top_turn_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_is_fall(phase)) |-> level == RAMP_W'(HI_CODE));

    assert_bottom_turn_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(phase_is_fall(phase)) |-> level == RAMP_W'(LO_CODE));

    assert_zero_step_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RISE && rise_step == '0 && extra_step == '0)
        |=> ($stable(level) && phase == PH_RISE));

endmodule

// File: rtl/ramp_blank.sv
module ramp_blank
    import ramp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      master_sel,
    input  logic      sync_in,
    input  phase_e    phase,
    output edge_out_t eo
);
    logic sync_q;
    logic blank_d;
    logic steer_q;
    logic blank_now;

    assign blank_now = phase_is_fall(phase) || (!master_sel && sync_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            blank_d <= 1'b0;
            steer_q <= 1'b0;
        end else begin
            sync_q  <= sync_in;
            blank_d <= blank_now;
            if (blank_now && !blank_d) begin
                steer_q <= !steer_q;
            end
        end
    end

    always_comb begin
        eo.blank   = blank_now;
        eo.clk_oe  = master_sel;
        eo.clk_drv = master_sel && phase_is_fall(phase);
        eo.steer   = steer_q;
    end

    assert_steer_after_blank_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(steer_q) |-> $past(blank_now));

endmodule

// File: rtl/ramp_timebase.sv
module ramp_timebase
    import ramp_pkg::*;
#(
    parameter int unsigned RAMP_W     = 12,
    parameter int unsigned STEP_W     = 6,
    parameter int unsigned LO_CODE    = 100,
    parameter int unsigned HI_CODE    = 280,
    parameter int unsigned FALL_RATIO = DEF_FALL_RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STEP_W-1:0] rise_step,
    input  logic [STEP_W-1:0] extra_step,
    input  logic              master_sel,
    input  logic              sync_in,
    output logic [RAMP_W-1:0] ramp_level,
    output logic              fall_phase,
    output logic              blank,
    output logic              sync_out,
    output logic              sync_oe,
    output logic              steer
);
    phase_e    phase;
    edge_out_t eo;

    ramp_core #(
        .RAMP_W    (RAMP_W),
        .STEP_W    (STEP_W),
        .LO_CODE   (LO_CODE),
        .HI_CODE   (HI_CODE),
        .FALL_RATIO(FALL_RATIO)
    ) u_core (
        .clk       (clk),
        .rst       (rst),
        .rise_step (rise_step),
        .extra_step(extra_step),
        .level     (ramp_level),
        .phase     (phase)
    );

    ramp_blank u_blank (
        .clk       (clk),
        .rst       (rst),
        .master_sel(master_sel),
        .sync_in   (sync_in),
        .phase     (phase),
        .eo        (eo)
    );

    assign fall_phase = phase_is_fall(phase);
    assign blank      = eo.blank;
    assign sync_out   = eo.clk_drv;
    assign sync_oe    = eo.clk_oe;
    assign steer      = eo.steer;

    assert_fall_blanks_R4: assert property (@(posedge clk) disable iff (rst)
        fall_phase |-> blank);

    assert_pin_inside_fall_R5: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> (fall_phase && sync_oe));

    assert_slave_pin_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !sync_oe |-> !sync_out);

endmodule

// File: tb/sim_ramp_timebase.sv
`timescale 1ns/100ps
module sim_ramp_timebase;
    localparam int RW = 12;
    localparam int SW = 6;
    localparam int LO = 100;
    localparam int HI = 280;
    localparam int FR = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [SW-1:0] rise_step = '0;
    logic [SW-1:0] extra_step = '0;
    logic master_sel = 1'b1;
    logic sync_in = 1'b0;
    logic [RW-1:0] ramp_level;
    logic fall_phase, blank, sync_out, sync_oe, steer;

    always #2.5 clk = ~clk;

    ramp_timebase #(.RAMP_W(RW), .STEP_W(SW), .LO_CODE(LO), .HI_CODE(HI), .FALL_RATIO(FR)) u0 (
        .clk(clk), .rst(rst), .rise_step(rise_step), .extra_step(extra_step),
        .master_sel(master_sel), .sync_in(sync_in), .ramp_level(ramp_level),
        .fall_phase(fall_phase), .blank(blank), .sync_out(sync_out),
        .sync_oe(sync_oe), .steer(steer));

    typedef struct {
        int   lvl;
        logic fall;
        logic blk;
        logic sout;
        logic soe;
        logic str;
    } exp_t;

    exp_t q[$];
    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    int   m_lvl = LO;
    logic m_fall = 0, m_steer = 0, m_blank_d = 0, m_syncq = 0;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input int r, input int e, input logic ms, input logic si);
        logic pre_blank;
        int up, dn;
        exp_t x;
        @(negedge clk);
        rise_step = SW'(r); extra_step = SW'(e); master_sel = ms; sync_in = si;
        pre_blank = m_fall | (!ms & m_syncq);
        m_steer   = m_steer ^ (pre_blank & !m_blank_d);
        m_blank_d = pre_blank;
        m_syncq   = si;
        if (!m_fall) begin
            up = r + e;
            if (up != 0) begin
                if (m_lvl + up >= HI) begin m_lvl = HI; m_fall = 1; end
                else m_lvl = m_lvl + up;
            end
        end else begin
            dn = FR * r;
            if (dn != 0) begin
                if (m_lvl <= LO + dn) begin m_lvl = LO; m_fall = 0; end
                else m_lvl = m_lvl - dn;
            end
        end
        x.lvl = m_lvl; x.fall = m_fall;
        x.blk = m_fall | (!ms & si);
        x.sout = ms & m_fall; x.soe = ms; x.str = m_steer;
        q.push_back(x);
    endtask

    initial begin : monitor
        exp_t x;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() != 0) begin
                x = q.pop_front();
                chk("R2/R3/R8 ramp_level", ramp_level, x.lvl);
                chk("R2/R3 fall_phase", fall_phase, x.fall);
                chk("R4/R6 blank", blank, x.blk);
                chk("R5/R6 sync_out", sync_out, x.sout);
                chk("R5/R6 sync_oe", sync_oe, x.soe);
                chk("R7 steer", steer, x.str);
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        int fall_cnt;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 ramp_level", ramp_level, LO);
        chk("R1 fall_phase", fall_phase, 0);
        chk("R1 blank", blank, 0);
        chk("R1 sync_out", sync_out, 0);
        chk("R1 steer", steer, 0);
        @(negedge clk);
        rst = 1'b0;
        // R2/R3/R5 master, plain rate
        for (int i = 0; i < 250; i++) drive(2, 0, 1, 0);
        for (int i = 0; i < 220; i++) drive(1, 0, 1, 0);
        // R8 extra step for dead time
        for (int i = 0; i < 200; i++) drive(2, 5, 1, 0);
        // R2/R3 overshoot clamps with large steps
        for (int i = 0; i < 40; i++) drive(63, 63, 1, 0);
        for (int i = 0; i < 30; i++) drive(7, 0, 1, 0);
        // R9 zero step holds in both phases
        for (int i = 0; i < 20; i++) drive(0, 0, 1, 0);
        while (!m_fall) drive(5, 0, 1, 0);
        for (int i = 0; i < 20; i++) drive(0, 9, 1, 0);
        // R6 slave: pin pulses blank but never move the ramp
        for (int i = 0; i < 300; i++) drive(3, 1, 0, (i % 7 == 2) || (i % 11 == 5));
        for (int i = 0; i < 60; i++) drive(3, 0, 0, 1);
        for (int i = 0; i < 30; i++) drive(3, 0, 1, 0);
        // R8 directed: fall length uses base step only
        while (m_fall) drive(1, 0, 1, 0);
        while (!m_fall) drive(1, 20, 1, 0);
        fall_cnt = 0;
        while (m_fall) begin drive(1, 20, 1, 0); fall_cnt++; end
        chk("R8 fall cycles with extra step", fall_cnt, 18);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule